// File: doc/BRIEF.md
# Segment Lookaside Table with Invalidation

This block holds a small, fully associative table of address-segment entries for a 64-bit translation front end. Each entry pairs an effective-segment word, which carries the segment number and a valid flag, with a virtual-segment word, which carries the segment size code, a class bit, key bits and a page-size code. One entry can match an effective address under either of two segment granularities, 256 MB or 1 TB. Both tests run in parallel, and the lowest-numbered matching entry wins.

Software-style operations arrive on a single command port, one per cycle. The command port is always ready. The operations are an associative lookup, a checked store into a numbered slot, indexed reads of either word, a lookup that returns only the virtual word, invalidation of one entry by address, and invalidation of the whole table under a hint code. Every command produces a one-cycle registered response in the next cycle. A rejected command raises an error flag in that response. Invalidations also pulse a local or a global translation-cache flush request.

Two mode inputs change behaviour. `mode_v3` enables the extended hint rules for invalidate-all, and `seg1t_en` permits 1 TB segments. A third input, `mode64`, selects whether the virtual-word lookup uses the full address or only its low 32 bits.

Top module: `seg_lookaside`

## Requirements
- R1: Command op codes: 0 lookup, 1 store, 2 read effective word, 3 read virtual word, 4 virtual-word lookup, 5 invalidate one (local), 6 invalidate one (global), 7 invalidate all. The response appears with `rsp_valid` in the cycle after `cmd_valid`. A lookup hits an entry whose effective word equals the address with bits 27:0 cleared and bit 27 (valid) set, provided the entry's size code (virtual word bits 63:62) is 00. On a hit, `rsp_data` is that entry's virtual word; on a miss it is 0.
- R2: A lookup also hits an entry whose effective word equals the address with bits 39:0 cleared and bit 27 set, provided the entry's size code is 01.
- R3: When several entries match, `rsp_index` and `rsp_data` come from the lowest-numbered one.
- R4: A store takes the slot from address bits 11:0, the effective word from the address with bits 11:0 cleared, and the virtual word from `cmd_data`. An accepted store writes both words and responds with `rsp_err` low.
- R5: A store is rejected, with `rsp_err` high and the table unchanged, in any of these cases: the slot is not below the table size; any of effective-word bits 26:12 is set; virtual bit 63 is set; the size code is 01 while `seg1t_en` is low; or the page-size code {bit 8, bits 5:4} is not in the supported set (default 0, 4, 5, 7).
- R6: An indexed read returns the selected word of the slot given by address bits 11:0. A slot at or above the table size raises `rsp_err` and returns 0.
- R7: The virtual-word lookup returns the hit entry's virtual word, or all ones on a miss. When `mode64` is low, address bits 63:32 are treated as zero before matching.
- R8: Invalidate-one clears the valid bit of the matching entry and pulses `flush_local` (op 5) or `flush_global` (op 6). On a miss, no entry changes and neither flush pulses.
- R9: Invalidate-all always pulses `flush_local`. By default it clears the valid bit of entries 1 to N-1 and leaves entry 0 intact.
- R10: With `mode_v3` high and hint 7, invalidate-all clears no entries but still pulses `flush_local`.
- R11: With `mode_v3` high, hints 3 and 4 also clear entry 0. Hint 3 keeps every entry whose class bit (virtual bit 7) is 0.
- R12: Hint 5, and every hint while `mode_v3` is low, behaves as hint 0.
- R13: After reset every entry reads as zero, so it is invalid, and `rsp_valid`, `flush_local` and `flush_global` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_v3 | input | 1 | Enables the extended invalidate-all hint rules |
| seg1t_en | input | 1 | Permits storing 1 TB segments |
| mode64 | input | 1 | Full 64-bit address for the virtual-word lookup |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Always high |
| cmd_op | input | 3 | Operation code |
| cmd_addr | input | 64 | Address or slot/effective-word operand |
| cmd_data | input | 64 | Virtual word for a store |
| cmd_hint | input | 3 | Invalidate-all hint |
| rsp_valid | output | 1 | Response valid, one cycle after the command |
| rsp_err | output | 1 | Command rejected |
| rsp_hit | output | 1 | An associative search hit |
| rsp_index | output | IDX_W | Index of the hit entry |
| rsp_data | output | 64 | Read or lookup result |
| flush_local | output | 1 | Local translation-cache flush request |
| flush_global | output | 1 | Global translation-cache flush request |

## Verification
The hardest case to reach is a table state that separates the invalidate-all variants. Entry 0 must be valid with its class bit set, and the neighbouring entries must mix class 0 and class 1, so that hints 3, 4, 5 and 7 each leave a different set of valid bits. The bench builds that state with checked stores. It then makes the survivors visible by reading back effective words through the indexed-read operation. The same approach shows the lowest-index priority: the bench stores one segment twice, invalidates the first copy by address, and watches the hit move to the second slot.

// File: rtl/slb_pkg.sv
// Package: shared field positions, masks and op codes for the segment table.
// Assumes 64-bit effective and virtual words with a fixed field layout.
package slb_pkg;
    localparam int WORD_W    = 64;
    localparam int V_BIT     = 27;
    localparam int SZ_HI     = 63;
    localparam int SZ_LO     = 62;
    localparam int CLASS_BIT = 7;
    localparam int L_BIT     = 8;
    localparam int LP_HI     = 5;
    localparam int LP_LO     = 4;

    localparam logic [WORD_W-1:0] MASK_256M = 64'hFFFF_FFFF_F000_0000;
    localparam logic [WORD_W-1:0] MASK_1T   = 64'hFFFF_FF00_0000_0000;
    localparam logic [WORD_W-1:0] VBIT_MASK = 64'h0000_0000_0800_0000;

    localparam logic [1:0] SZ_256M = 2'b00;
    localparam logic [1:0] SZ_1T   = 2'b01;

    typedef enum logic [2:0] {
        OP_LOOKUP  = 3'd0,
        OP_STORE   = 3'd1,
        OP_RD_ESID = 3'd2,
        OP_RD_VSID = 3'd3,
        OP_FIND    = 3'd4,
        OP_INV_ONE = 3'd5,
        OP_INV_GLB = 3'd6,
        OP_INV_ALL = 3'd7
    } slb_op_e;
endpackage

// File: rtl/slb_match.sv
// Module: parallel match of one address against every entry, at both segment
// granularities, followed by a lowest-index priority encoder.
// Assumes the entry size codes are already sliced out of the virtual words.
module slb_match
    import slb_pkg::*;
#(
    parameter int N     = 32,
    parameter int IDX_W = 5
) (
    input  logic [WORD_W-1:0]         addr_i,
    input  logic [N-1:0][WORD_W-1:0]  esid_i,
    input  logic [N-1:0][1:0]         size_i,
    output logic [N-1:0]              match_o,
    output logic                      hit_o,
    output logic [IDX_W-1:0]          idx_o
);
    logic [WORD_W-1:0] key_256m;
    logic [WORD_W-1:0] key_1t;

    assign key_256m = (addr_i & MASK_256M) | VBIT_MASK;
    assign key_1t   = (addr_i & MASK_1T) | VBIT_MASK;

    for (genvar i = 0; i < N; i++) begin : g_cmp
        assign match_o[i] = ((esid_i[i] == key_256m) && (size_i[i] == SZ_256M)) ||
                            ((esid_i[i] == key_1t)   && (size_i[i] == SZ_1T));
    end

    // Priority encode: the lowest-numbered match wins.
    always_comb begin
        hit_o = 1'b0;
        idx_o = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (match_o[i]) begin
                hit_o = 1'b1;
                idx_o = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/slb_store_check.sv
// Module: validity test for a store into the table.
// Assumes the effective word has its low 12 bits already cleared.
module slb_store_check
    import slb_pkg::*;
#(
    parameter int         N      = 32,
    parameter logic [7:0] PSZ_OK = 8'b1011_0001
) (
    input  logic [11:0]       slot_i,
    input  logic [WORD_W-1:0] esid_i,
    input  logic [1:0]        size_i,
    input  logic [2:0]        psz_i,
    input  logic              seg1t_en_i,
    output logic              ok_o
);
    logic slot_ok, rsvd_ok, size_ok, psz_ok;

    // Each rejection reason is evaluated separately, then combined.
    always_comb begin
        slot_ok = ({1'b0, slot_i} < 13'(N));
        rsvd_ok = ((esid_i & ~(MASK_256M | VBIT_MASK)) == '0);
        size_ok = !size_i[1] && !(size_i[0] && !seg1t_en_i);
        psz_ok  = PSZ_OK[psz_i];
        ok_o    = slot_ok && rsvd_ok && size_ok && psz_ok;
    end
endmodule

// File: rtl/slb_inval_sel.sv
// Module: chooses which entries an invalidate-all clears, from the hint code
// and the mode. Assumes the class bits come straight from the stored words.
module slb_inval_sel #(
    parameter int N = 32
) (
    input  logic [N-1:0] valid_i,
    input  logic [N-1:0] class_i,
    input  logic [2:0]   hint_i,
    input  logic         v3_i,
    output logic [N-1:0] clr_o
);
    logic skip_all, take_zero, keep_c0;

    // Decode the hint into the three rule modifiers.
    always_comb begin
        skip_all  = v3_i && (hint_i == 3'd7);
        take_zero = v3_i && ((hint_i == 3'd3) || (hint_i == 3'd4));
        keep_c0   = v3_i && (hint_i == 3'd3);
    end

    for (genvar i = 0; i < N; i++) begin : g_sel
        if (i == 0) begin : g_zero
            assign clr_o[i] = valid_i[i] && !skip_all && take_zero &&
                              !(keep_c0 && !class_i[i]);
        end else begin : g_rest
            assign clr_o[i] = valid_i[i] && !skip_all &&
                              !(keep_c0 && !class_i[i]);
        end
    end
endmodule

// File: rtl/seg_lookaside.sv
// Module: segment lookaside table top. Holds N entry pairs in flops, serves
// one command per cycle with a registered response, and raises flush pulses.
// Assumes N <= 4096 and that the command port never back-pressures.
module seg_lookaside
    import slb_pkg::*;
#(
    parameter int         N      = 32,
    parameter logic [7:0] PSZ_OK = 8'b1011_0001,
    localparam int        IDX_W  = (N > 1) ? $clog2(N) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_v3,
    input  logic              seg1t_en,
    input  logic              mode64,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic [2:0]        cmd_op,
    input  logic [63:0]       cmd_addr,
    input  logic [63:0]       cmd_data,
    input  logic [2:0]        cmd_hint,
    output logic              rsp_valid,
    output logic              rsp_err,
    output logic              rsp_hit,
    output logic [IDX_W-1:0]  rsp_index,
    output logic [63:0]       rsp_data,
    output logic              flush_local,
    output logic              flush_global
);
    logic [N-1:0][WORD_W-1:0] esid_q, vsid_q;
    logic [N-1:0]             valid_vec, class_vec, match_vec, clr_vec;
    logic [N-1:0][1:0]        size_vec;
    slb_op_e                  op, op_q;
    logic [WORD_W-1:0]        lk_addr, esid_word, rd_word;
    logic [11:0]              slot;
    logic [IDX_W-1:0]         slot_idx, hit_idx;
    logic                     slot_in, hit, store_ok;
    logic [2:0]               psz;

    assign cmd_ready = 1'b1;

    for (genvar i = 0; i < N; i++) begin : g_fields
        assign valid_vec[i] = esid_q[i][V_BIT];
        assign class_vec[i] = vsid_q[i][CLASS_BIT];
        assign size_vec[i]  = vsid_q[i][SZ_HI:SZ_LO];
    end

    // Decode the command operands.
    always_comb begin
        op        = slb_op_e'(cmd_op);
        lk_addr   = (op == OP_FIND && !mode64) ? {32'h0, cmd_addr[31:0]} : cmd_addr;
        slot      = cmd_addr[11:0];
        slot_in   = ({1'b0, slot} < 13'(N));
        slot_idx  = slot[IDX_W-1:0];
        esid_word = {cmd_addr[63:12], 12'h000};
        psz       = {cmd_data[L_BIT], cmd_data[LP_HI:LP_LO]};
        rd_word   = (op == OP_RD_ESID) ? esid_q[slot_idx] : vsid_q[slot_idx];
    end

    slb_match #(.N(N), .IDX_W(IDX_W)) u_match (
        .addr_i (lk_addr),
        .esid_i (esid_q),
        .size_i (size_vec),
        .match_o(match_vec),
        .hit_o  (hit),
        .idx_o  (hit_idx)
    );

    slb_store_check #(.N(N), .PSZ_OK(PSZ_OK)) u_chk (
        .slot_i    (slot),
        .esid_i    (esid_word),
        .size_i    (cmd_data[SZ_HI:SZ_LO]),
        .psz_i     (psz),
        .seg1t_en_i(seg1t_en),
        .ok_o      (store_ok)
    );

    slb_inval_sel #(.N(N)) u_inv (
        .valid_i(valid_vec),
        .class_i(class_vec),
        .hint_i (cmd_hint),
        .v3_i   (mode_v3),
        .clr_o  (clr_vec)
    );

    // Table update and registered response for the command of this cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N; i++) begin
                esid_q[i] <= '0;
                vsid_q[i] <= '0;
            end
            rsp_valid    <= 1'b0;
            rsp_err      <= 1'b0;
            rsp_hit      <= 1'b0;
            rsp_index    <= '0;
            rsp_data     <= '0;
            flush_local  <= 1'b0;
            flush_global <= 1'b0;
            op_q         <= OP_LOOKUP;
        end else begin
            rsp_valid    <= cmd_valid;
            rsp_err      <= 1'b0;
            rsp_hit      <= 1'b0;
            rsp_index    <= '0;
            rsp_data     <= '0;
            flush_local  <= 1'b0;
            flush_global <= 1'b0;
            op_q         <= op;
            if (cmd_valid) begin
                case (op)
                    OP_LOOKUP: begin
                        rsp_hit   <= hit;
                        rsp_index <= hit_idx;
                        rsp_data  <= hit ? vsid_q[hit_idx] : '0;
                    end
                    OP_STORE: begin
                        if (store_ok) begin
                            esid_q[slot_idx] <= esid_word;
                            vsid_q[slot_idx] <= cmd_data;
                        end else begin
                            rsp_err <= 1'b1;
                        end
                    end
                    OP_RD_ESID, OP_RD_VSID: begin
                        rsp_err  <= !slot_in;
                        rsp_data <= slot_in ? rd_word : '0;
                    end
                    OP_FIND: begin
                        rsp_hit   <= hit;
                        rsp_index <= hit_idx;
                        rsp_data  <= hit ? vsid_q[hit_idx] : '1;
                    end
                    OP_INV_ONE, OP_INV_GLB: begin
                        rsp_hit   <= hit;
                        rsp_index <= hit_idx;
                        if (hit) begin
                            esid_q[hit_idx][V_BIT] <= 1'b0;
                            flush_local  <= (op == OP_INV_ONE);
                            flush_global <= (op == OP_INV_GLB);
                        end
                    end
                    OP_INV_ALL: begin
                        for (int i = 0; i < N; i++) begin
                            if (clr_vec[i]) esid_q[i][V_BIT] <= 1'b0;
                        end
                        flush_local <= 1'b1;
                    end
                    default: ;
                endcase
            end
        end
    end

    // R4: an accepted store lands in the addressed slot.
    a_r4_store_writes: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && op == OP_STORE && store_ok |=>
            !rsp_err && esid_q[$past(slot_idx)] == $past(esid_word));

    // R5: a rejected store flags an error and leaves validity untouched.
    a_r5_reject_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && op == OP_STORE && !store_ok |=> rsp_err && $stable(valid_vec));

    // R7: a virtual-word lookup miss returns all ones.
    a_r7_miss_ones: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && op_q == OP_FIND && !rsp_hit |-> rsp_data == '1);

    // R8: a single invalidate never raises both flush kinds.
    a_r8_one_flush_kind: assert property (@(posedge clk) disable iff (!rst_n)
        !(flush_local && flush_global));

    // R9: invalidate-all always requests a local flush.
    a_r9_all_flushes: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && op == OP_INV_ALL |=> flush_local);

    // R9 / R12: outside the extended mode, entry 0 survives invalidate-all.
    a_r9_entry0_kept: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && op == OP_INV_ALL && !mode_v3 |=> valid_vec[0] == $past(valid_vec[0]));

    // R10: hint 7 in the extended mode leaves all valid bits alone.
    a_r10_hint7_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && op == OP_INV_ALL && mode_v3 && cmd_hint == 3'd7 |=> $stable(valid_vec));
endmodule

// File: tb/sim_seg_lookaside.sv
`timescale 1ns/1ps
module sim_seg_lookaside;
    localparam int N = 32;
    localparam int IDX_W = 5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mode_v3 = 1'b0, seg1t_en = 1'b1, mode64 = 1'b1;
    logic        cmd_valid = 1'b0;
    logic        cmd_ready;
    logic [2:0]  cmd_op = '0;
    logic [63:0] cmd_addr = '0, cmd_data = '0;
    logic [2:0]  cmd_hint = '0;
    logic        rsp_valid, rsp_err, rsp_hit, flush_local, flush_global;
    logic [IDX_W-1:0] rsp_index;
    logic [63:0] rsp_data;

    int total = 0;
    int fails = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    seg_lookaside #(.N(N)) u0 (
        .clk(clk), .rst_n(rst_n), .mode_v3(mode_v3), .seg1t_en(seg1t_en),
        .mode64(mode64), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_op(cmd_op), .cmd_addr(cmd_addr), .cmd_data(cmd_data),
        .cmd_hint(cmd_hint), .rsp_valid(rsp_valid), .rsp_err(rsp_err),
        .rsp_hit(rsp_hit), .rsp_index(rsp_index), .rsp_data(rsp_data),
        .flush_local(flush_local), .flush_global(flush_global)
    );

    localparam logic [2:0] LK = 3'd0, ST = 3'd1, RE = 3'd2, RV = 3'd3,
                           FD = 3'd4, IO = 3'd5, IG = 3'd6, IA = 3'd7;

    typedef struct packed {
        logic [2:0]  op;
        logic [63:0] addr;
        logic [63:0] data;
        logic        e_err;
        logic        e_hit;
        logic [63:0] e_data;
    } vec_t;

    localparam int NV = 18;
    localparam vec_t VT [NV] = '{
        '{ST, 64'h0000_0001_2800_0002, 64'h0000_0000_1234_0080, 1'b0, 1'b0, 64'h0},
        '{ST, 64'h0000_0001_2800_0009, 64'h0000_0000_0000_9900, 1'b0, 1'b0, 64'h0},
        '{ST, 64'h0000_0300_0800_0005, 64'h4000_0000_00AB_0000, 1'b0, 1'b0, 64'h0},
        '{ST, 64'h0000_0000_2800_0000, 64'h0000_0000_0000_5500, 1'b0, 1'b0, 64'h0},
        '{LK, 64'h0000_0001_2345_6789, 64'h0, 1'b0, 1'b1, 64'h0000_0000_1234_0080},
        '{LK, 64'h0000_0312_3456_7890, 64'h0, 1'b0, 1'b1, 64'h4000_0000_00AB_0000},
        '{LK, 64'h0000_0301_2000_0000, 64'h0, 1'b0, 1'b1, 64'h4000_0000_00AB_0000},
        '{LK, 64'h0000_0001_3000_0000, 64'h0, 1'b0, 1'b0, 64'h0},
        '{ST, 64'h0000_0001_2800_0028, 64'h0000_0000_0000_0000, 1'b1, 1'b0, 64'h0},
        '{ST, 64'h0000_0001_2810_0003, 64'h0000_0000_0000_0000, 1'b1, 1'b0, 64'h0},
        '{ST, 64'h0000_0001_2800_0003, 64'h8000_0000_0000_0000, 1'b1, 1'b0, 64'h0},
        '{ST, 64'h0000_0001_2800_0003, 64'h0000_0000_0000_0010, 1'b1, 1'b0, 64'h0},
        '{RE, 64'h0000_0000_0000_0002, 64'h0, 1'b0, 1'b0, 64'h0000_0001_2800_0000},
        '{RV, 64'h0000_0000_0000_0005, 64'h0, 1'b0, 1'b0, 64'h4000_0000_00AB_0000},
        '{RE, 64'h0000_0000_0000_0003, 64'h0, 1'b0, 1'b0, 64'h0},
        '{RV, 64'h0000_0000_0000_0020, 64'h0, 1'b1, 1'b0, 64'h0},
        '{FD, 64'h0000_0001_2345_6789, 64'h0, 1'b0, 1'b1, 64'h0000_0000_1234_0080},
        '{FD, 64'h0000_0001_3000_0000, 64'h0, 1'b0, 1'b0, 64'hFFFF_FFFF_FFFF_FFFF}
    };

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Drive one command; on return the response is visible on the outputs.
    task automatic issue(input logic [2:0] op, input logic [63:0] a,
                         input logic [63:0] d, input logic [2:0] h);
        @(negedge clk);
        cmd_op = op; cmd_addr = a; cmd_data = d; cmd_hint = h; cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic read_esid(input int slot, input logic [63:0] exp, input string req);
        issue(RE, 64'(slot), 64'h0, 3'd0);
        chk(req, rsp_data, exp);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R13: reset state
        chk("R13 rsp_valid", 64'(rsp_valid), 64'h0);
        chk("R13 flushes", {62'h0, flush_local, flush_global}, 64'h0);
        read_esid(0, 64'h0, "R13 entry0 empty");
        issue(LK, 64'h0, 64'h0, 3'd0);
        chk("R13 empty lookup miss", 64'(rsp_hit), 64'h0);

        // Table walk: R1 R2 R4 R5 R6 R7
        for (int k = 0; k < NV; k++) begin
            issue(VT[k].op, VT[k].addr, VT[k].data, 3'd0);
            chk($sformatf("R1/R2/R4/R5/R6/R7 vec%0d valid", k), 64'(rsp_valid), 64'h1);
            chk($sformatf("R4/R5/R6 vec%0d err", k), 64'(rsp_err), 64'(VT[k].e_err));
            chk($sformatf("R1/R2/R7 vec%0d hit", k), 64'(rsp_hit), 64'(VT[k].e_hit));
            chk($sformatf("R1/R2/R6/R7 vec%0d data", k), rsp_data, VT[k].e_data);
        end

        // R3: lowest index wins between slots 2 and 9
        issue(LK, 64'h0000_0001_2345_6789, 64'h0, 3'd0);
        chk("R3 index lowest", 64'(rsp_index), 64'd2);

        // R5: 1 TB segment rejected when disabled
        seg1t_en = 1'b0;
        issue(ST, 64'h0000_0400_0800_0006, 64'h4000_0000_0000_0000, 3'd0);
        chk("R5 1T disabled err", 64'(rsp_err), 64'h1);
        seg1t_en = 1'b1;
        read_esid(6, 64'h0, "R5 slot6 untouched");

        // R7: 32-bit address masking
        mode64 = 1'b0;
        issue(FD, 64'hFFFF_FFFF_2345_6789, 64'h0, 3'd0);
        chk("R7 masked find hit", rsp_data, 64'h0000_0000_0000_5500);
        mode64 = 1'b1;
        issue(FD, 64'hFFFF_FFFF_2345_6789, 64'h0, 3'd0);
        chk("R7 unmasked find miss", rsp_data, 64'hFFFF_FFFF_FFFF_FFFF);

        // R8: single invalidates, local then global, then a miss
        issue(IO, 64'h0000_0001_2345_6789, 64'h0, 3'd0);
        chk("R8 local flush", {62'h0, flush_local, flush_global}, 64'h2);
        issue(LK, 64'h0000_0001_2345_6789, 64'h0, 3'd0);
        chk("R8/R3 next match slot9", 64'(rsp_index), 64'd9);
        issue(IG, 64'h0000_0001_2345_6789, 64'h0, 3'd0);
        chk("R8 global flush", {62'h0, flush_local, flush_global}, 64'h1);
        issue(LK, 64'h0000_0001_2345_6789, 64'h0, 3'd0);
        chk("R8 both cleared", 64'(rsp_hit), 64'h0);
        issue(IO, 64'h0000_0007_0000_0000, 64'h0, 3'd0);
        chk("R8 miss no flush", {61'h0, rsp_hit, flush_local, flush_global}, 64'h0);

        // R9 R12: legacy mode, hint 3 behaves as hint 0
        mode_v3 = 1'b0;
        issue(IA, 64'h0, 64'h0, 3'd3);
        chk("R9 inv-all flush", {62'h0, flush_local, flush_global}, 64'h2);
        read_esid(0, 64'h0000_0000_2800_0000, "R9 entry0 kept");
        read_esid(5, 64'h0000_0300_0000_0000, "R9 entry5 cleared");

        // R10: extended mode, hint 7 clears nothing
        issue(ST, 64'h0000_0300_0800_0005, 64'h4000_0000_00AB_0000, 3'd0);
        mode_v3 = 1'b1;
        issue(IA, 64'h0, 64'h0, 3'd7);
        chk("R10 hint7 flush", 64'(flush_local), 64'h1);
        read_esid(5, 64'h0000_0300_0800_0000, "R10 entry5 kept");
        read_esid(0, 64'h0000_0000_2800_0000, "R10 entry0 kept");

        // R12: hint 5 acts as hint 0 in extended mode
        issue(IA, 64'h0, 64'h0, 3'd5);
        read_esid(0, 64'h0000_0000_2800_0000, "R12 hint5 entry0 kept");
        read_esid(5, 64'h0000_0300_0000_0000, "R12 hint5 entry5 cleared");

        // R11: hint 3 covers entry 0 and keeps class-0 entries
        issue(ST, 64'h0000_0000_2800_0000, 64'h0000_0000_0000_5580, 3'd0);
        issue(ST, 64'h0000_0002_2800_0001, 64'h0000_0000_0000_0000, 3'd0);
        issue(ST, 64'h0000_0001_2800_0002, 64'h0000_0000_1234_0080, 3'd0);
        issue(IA, 64'h0, 64'h0, 3'd3);
        read_esid(0, 64'h0000_0000_2000_0000, "R11 hint3 entry0 class1 cleared");
        read_esid(1, 64'h0000_0002_2800_0000, "R11 hint3 entry1 class0 kept");
        read_esid(2, 64'h0000_0001_2000_0000, "R11 hint3 entry2 class1 cleared");

        // R11: hint 4 clears regardless of class
        issue(IA, 64'h0, 64'h0, 3'd4);
        read_esid(1, 64'h0000_0002_2000_0000, "R11 hint4 entry1 cleared");

        done = 1'b1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule